// File: doc/BRIEF.md
# RTC Prescaler and Periodic-Rate Generator

This block is the front end of a real-time clock. A one-cycle reference enable (`ref_en`, one pulse per 32.768 kHz reference period) advances a 15-stage binary divider. The divider produces a one-second update strobe, a programmable periodic event and square wave, and an update-in-progress status flag that the host can poll. A single 8-bit control register selects the reference mode and the periodic rate. The host writes it through `wr_en`/`wr_data` and reads it back on `reg_rdata`, together with the live status flag in bit 7.

The mode field occupies bits 6:4. Code 010 runs the divider from the 32.768 kHz reference. Codes 110 and 111 hold the divider in its reset state, which is half-way through a second. Every other code freezes the divider at its current count. Codes 000 and 001 are decoded as the 4.194 MHz and 1.049 MHz references, but no divider is built for them. The rate field occupies bits 3:0. Code 0 turns the periodic output off. Code n from 1 to 15 gives a rate of 32768 >> (n-1) Hz.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, `reg_rdata` reads 0x60 (mode 110, rate 0). `sec_tick`, `pe_pulse`, `sqw_out` and `uip` are all low.
- R2: While the mode field (bits 6:4) is 110 or 111, the divider is held at its half-second count, and no `sec_tick` or `pe_pulse` occurs. On the first write of mode 010 after that, the first `sec_tick` comes 16384 reference ticks after the write.
- R3: In mode 010, `sec_tick` pulses high for exactly one cycle, once every 32768 reference ticks.
- R4: With rate code n in bits 3:0 (1 to 15) and mode 010, `pe_pulse` is a one-cycle pulse every 2^(n-1) reference ticks. With rate code 0, `pe_pulse` never fires.
- R5: With `sqw_en` high and rate n of 2 or more, `sqw_out` is a square wave whose period is 2^(n-1) reference ticks, and it falls together with each `pe_pulse`. With n = 1, `sqw_out` toggles on every reference tick. When `sqw_en` is low or the rate is 0, `sqw_out` is low from the next cycle on.
- R6: `uip` (also `reg_rdata` bit 7) rises 8 reference ticks before each `sec_tick` and falls 65 reference ticks after it.
- R7: Bit 7 of a write is ignored. `reg_rdata[6:0]` returns the written bits 6:0 in the cycle after the write.
- R8: Mode codes 000, 001, 011, 100 and 101 freeze the divider without clearing it, and produce no `sec_tick` or `pe_pulse`. A later return to 010 resumes the count where it stopped.
- R9: The divider advances only in cycles where `ref_en` is high. All event timing is counted in reference ticks, not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle enable per reference period |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| sqw_en | input | 1 | Square-wave output enable |
| reg_rdata | output | 8 | {uip, mode[2:0], rate[3:0]} |
| sec_tick | output | 1 | One-second update strobe |
| pe_pulse | output | 1 | Periodic event pulse |
| sqw_out | output | 1 | Square-wave output |
| uip | output | 1 | Update-in-progress status |

## Verification
Every output is a register fed by the next divider value, so a result caused by the reference tick at clock edge k appears after edge k. A write takes effect from the following edge. With `ref_en` high every cycle, the first `sec_tick` is therefore due 16384 edges after the starting write, `uip` rises 8 edges earlier, and periodic pulses fall on multiples of 2^(n-1) edges after the write. The bench stores the absolute edge number of every expected pulse in queues, built from a reference-tick model that also handles the gated `ref_en` pattern. A monitor samples on the falling clock edge and matches each observed pulse against the head of its queue, so an early, late, missing or widened pulse is reported.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef enum logic [2:0] {
    SRC_4M   = 3'd0,
    SRC_1M   = 3'd1,
    SRC_32K  = 3'd2,
    SRC_HOLD = 3'd3,
    SRC_TEST = 3'd4
  } div_src_e;

  // Map the 3-bit mode field onto the divider behaviour.
  function automatic div_src_e decode_mode(input logic [2:0] code);
    case (code)
      3'b000:        return SRC_4M;
      3'b001:        return SRC_1M;
      3'b010:        return SRC_32K;
      3'b110, 3'b111: return SRC_HOLD;
      default:       return SRC_TEST;
    endcase
  endfunction

endpackage

// File: rtl/rtc_div_ctrl.sv
module rtc_div_ctrl #(
  parameter int        MODE_W  = 3,
  parameter int        RATE_W  = 4,
  parameter logic [6:0] RST_VAL = 7'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [MODE_W-1:0] mode,
  output logic [RATE_W-1:0] rate
);

  localparam int STORE_W = MODE_W + RATE_W;

  logic [STORE_W-1:0] store_q;

  // Bit 7 of the write data is not stored: the status bit is read-only.
  always_ff @(posedge clk) begin
    if (rst)        store_q <= RST_VAL[STORE_W-1:0];
    else if (wr_en) store_q <= wr_data[STORE_W-1:0];
  end

  assign mode = store_q[STORE_W-1:RATE_W];
  assign rate = store_q[RATE_W-1:0];

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int UIP_LEAD  = 8,
  parameter int UPD_TICKS = 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  div_src_e         src,
  output logic             adv,
  output logic             clr,
  output logic [DIV_W-1:0] cnt_nxt,
  output logic             sec_tick,
  output logic             uip
);

  localparam logic [DIV_W-1:0] CNT_MAX   = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] HALF      = DIV_W'(1) << (DIV_W - 1);
  localparam logic [DIV_W-1:0] UIP_START = CNT_MAX - DIV_W'(UIP_LEAD - 1);
  localparam logic [DIV_W-1:0] UPD_LIM   = DIV_W'(UPD_TICKS);

  logic [DIV_W-1:0] cnt_q;

  assign clr = (src == SRC_HOLD);
  assign adv = (src == SRC_32K) && ref_en;

  always_comb begin
    if (clr)      cnt_nxt = HALF;
    else if (adv) cnt_nxt = cnt_q + DIV_W'(1);
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= HALF;
      sec_tick <= 1'b0;
      uip      <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      sec_tick <= adv && (cnt_q == CNT_MAX);
      uip      <= (cnt_nxt >= UIP_START) || (cnt_nxt < UPD_LIM);
    end
  end

endmodule

// File: rtl/rtc_div_rate.sv
module rtc_div_rate #(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic              adv,
  input  logic              clr,
  input  logic [DIV_W-1:0]  cnt_nxt,
  input  logic              sqw_en,
  output logic              pe_pulse,
  output logic              sqw_out
);

  localparam logic [RATE_W-1:0] RATE_OFF = '0;
  localparam logic [RATE_W-1:0] RATE_TOP = RATE_W'(1);

  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] shifted;
  logic             hit;
  logic             tgl_q, tgl_nxt;
  logic             sq_bit;

  // Low (n-1) bits of the next count are zero once per 2^(n-1) ticks.
  always_comb begin
    if (rate == RATE_OFF) mask = '0;
    else                  mask = (DIV_W'(1) << (rate - RATE_W'(1))) - DIV_W'(1);
  end

  assign hit = adv && (rate != RATE_OFF) && ((cnt_nxt & mask) == '0);

  always_comb begin
    if (clr)      tgl_nxt = 1'b0;
    else if (adv) tgl_nxt = ~tgl_q;
    else          tgl_nxt = tgl_q;
  end

  assign shifted = cnt_nxt >> (rate - RATE_W'(2));
  assign sq_bit  = (rate == RATE_TOP) ? tgl_nxt : shifted[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q    <= 1'b0;
      pe_pulse <= 1'b0;
      sqw_out  <= 1'b0;
    end else begin
      tgl_q    <= tgl_nxt;
      pe_pulse <= hit;
      sqw_out  <= sqw_en && (rate != RATE_OFF) && sq_bit;
    end
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_div_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int UIP_LEAD  = 8,
  parameter int UPD_TICKS = 65
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       sqw_en,
  output logic [7:0] reg_rdata,
  output logic       sec_tick,
  output logic       pe_pulse,
  output logic       sqw_out,
  output logic       uip
);

  localparam int MODE_W = 3;
  localparam int RATE_W = 4;

  logic [MODE_W-1:0] mode;
  logic [RATE_W-1:0] rate;
  div_src_e          src;
  logic              adv, clr;
  logic [DIV_W-1:0]  cnt_nxt;

  rtc_div_ctrl #(.MODE_W(MODE_W), .RATE_W(RATE_W), .RST_VAL(7'h60)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .mode(mode), .rate(rate)
  );

  assign src = decode_mode(mode);

  rtc_div_chain #(.DIV_W(DIV_W), .UIP_LEAD(UIP_LEAD), .UPD_TICKS(UPD_TICKS)) u_chain (
    .clk(clk), .rst(rst), .ref_en(ref_en), .src(src),
    .adv(adv), .clr(clr), .cnt_nxt(cnt_nxt),
    .sec_tick(sec_tick), .uip(uip)
  );

  rtc_div_rate #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst(rst), .rate(rate), .adv(adv), .clr(clr),
    .cnt_nxt(cnt_nxt), .sqw_en(sqw_en),
    .pe_pulse(pe_pulse), .sqw_out(sqw_out)
  );

  assign reg_rdata = {uip, mode, rate};

endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_en,
  input logic       sqw_en,
  input logic [7:0] reg_rdata,
  input logic       sec_tick,
  input logic       pe_pulse,
  input logic       sqw_out,
  input logic       uip
);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick); // R3

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_rdata[6:5]) == 2'b11) |-> (!pe_pulse && !sec_tick)); // R2

  AST_RATE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    pe_pulse |-> ($past(reg_rdata[3:0]) != 4'd0)); // R4

  AST_SQW_GATED: assert property (@(posedge clk) disable iff (rst)
    !$past(sqw_en) |-> !sqw_out); // R5

  AST_UIP_AT_TICK: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> (uip && reg_rdata[7])); // R6

  AST_UIP_RISE_EARLY: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> !sec_tick); // R6

  AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    (sec_tick || pe_pulse) |-> $past(ref_en)); // R9

endmodule

bind rtc_prescaler rtc_prescaler_chk u_chk (.*);

// File: tb/rtc_prescaler_test.sv
`timescale 1ns/1ps
module rtc_prescaler_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sqw_en = 1'b0;
  logic [7:0] reg_rdata;
  logic       sec_tick, pe_pulse, sqw_out, uip;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit gate = 1'b0;
  bit done = 1'b0;
  int pe_q[$];
  int sec_q[$];

  rtc_prescaler uut (
    .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en), .wr_data(wr_data),
    .sqw_en(sqw_en), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .pe_pulse(pe_pulse), .sqw_out(sqw_out), .uip(uip)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) ref_en <= gate ? ((cyc + 1) % 3 == 0) : 1'b1;

  function automatic bit ref_on(int e, bit g);
    return g ? (e % 3 == 0) : 1'b1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic write_at(int t, logic [7:0] d);
    do @(negedge clk); while (cyc < t - 1);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic wait_until(int t);
    do @(negedge clk); while (cyc < t);
  endtask

  // Reference-tick model: push the edge number of every expected event.
  task automatic expect_run(int w, int stop, int rate, bit g, inout int cnt);
    for (int e = w + 1; e <= stop; e++) begin
      if (ref_on(e, g)) begin
        cnt = (cnt + 1) % 32768;
        if (rate != 0 && (cnt % (1 << (rate - 1))) == 0) pe_q.push_back(e);
        if (cnt == 0) sec_q.push_back(e);
      end
    end
  endtask

  // Monitor: compare observed pulses against the expected queues.
  always @(negedge clk) begin
    int ex;
    if (!rst && !done) begin
      while (pe_q.size() > 0 && pe_q[0] < cyc) begin
        chk(1'b0, "R4 missed periodic event", -1, pe_q[0]);
        ex = pe_q.pop_front();
      end
      if (pe_pulse) begin
        if (pe_q.size() == 0) chk(1'b0, "R4 unexpected periodic event", cyc, -1);
        else begin
          ex = pe_q.pop_front();
          chk(ex == cyc, "R4 periodic event edge", cyc, ex);
        end
      end
      while (sec_q.size() > 0 && sec_q[0] < cyc) begin
        chk(1'b0, "R2/R3 missed second tick", -1, sec_q[0]);
        ex = sec_q.pop_front();
      end
      if (sec_tick) begin
        if (sec_q.size() == 0) chk(1'b0, "R2/R3 unexpected second tick", cyc, -1);
        else begin
          ex = sec_q.pop_front();
          chk(ex == cyc, "R2/R3 second tick edge", cyc, ex);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #750000;
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int w, r, cnt, first;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h60, "R1 register reset value", reg_rdata, 8'h60);
    chk({sec_tick, pe_pulse, sqw_out, uip} == 4'b0, "R1 outputs low after reset",
        {sec_tick, pe_pulse, sqw_out, uip}, 0);
    sqw_en = 1'b1;
    wait_until(cyc + 50);
    chk(!pe_pulse && !sec_tick, "R2 held divider quiet", pe_pulse, 0);

    // Run at rate 3 through two second ticks.
    w = cyc + 2;
    write_at(w, 8'h23);
    cnt = 16384;
    expect_run(w, w + 49250, 3, 1'b0, cnt);
    wait_until(w);
    chk(reg_rdata[6:0] == 7'h23, "R7 readback", reg_rdata[6:0], 7'h23);
    wait_until(w + 4);
    chk(pe_pulse == 1'b1, "R4 first rate-3 event", pe_pulse, 1);
    wait_until(w + 5);
    chk(pe_pulse == 1'b0, "R4 pulse one cycle wide", pe_pulse, 0);
    wait_until(w + 10); chk(sqw_out == 1'b1, "R5 square wave rate 3", sqw_out, 1);
    wait_until(w + 12); chk(sqw_out == 1'b0, "R5 square wave rate 3", sqw_out, 0);
    wait_until(w + 13); chk(sqw_out == 1'b0, "R5 square wave rate 3", sqw_out, 0);
    wait_until(w + 14); chk(sqw_out == 1'b1, "R5 square wave rate 3", sqw_out, 1);
    wait_until(w + 16375); chk(uip == 1'b0, "R6 uip low before lead", uip, 0);
    wait_until(w + 16376);
    chk(uip == 1'b1 && reg_rdata[7], "R6 uip rises 8 ticks early", uip, 1);
    wait_until(w + 16384); chk(sec_tick == 1'b1, "R2 first tick after 16384", sec_tick, 1);
    wait_until(w + 16448); chk(uip == 1'b1, "R6 uip held through update", uip, 1);
    wait_until(w + 16449); chk(uip == 1'b0, "R6 uip falls 65 ticks after", uip, 0);
    wait_until(w + 49144); chk(uip == 1'b1, "R6 uip second rise", uip, 1);
    wait_until(w + 49152); chk(sec_tick == 1'b1, "R3 second tick after 32768", sec_tick, 1);
    wait_until(w + 49217); chk(uip == 1'b0, "R6 uip second fall", uip, 0);
    write_at(w + 49250, 8'hFF);
    wait_until(w + 49250);
    chk(reg_rdata == 8'h7F, "R7 bit 7 write ignored", reg_rdata, 8'h7F);
    wait_until(w + 49350);
    chk(!pe_pulse && !sec_tick, "R2 mode 111 holds divider", pe_pulse, 0);

    // Rate 1: event on every tick, square wave toggles each tick.
    w = cyc + 2;
    write_at(w, 8'h21);
    cnt = 16384;
    expect_run(w, w + 40, 1, 1'b0, cnt);
    wait_until(w + 1); chk(sqw_out == 1'b1, "R5 rate 1 toggle", sqw_out, 1);
    wait_until(w + 2); chk(sqw_out == 1'b0, "R5 rate 1 toggle", sqw_out, 0);
    wait_until(w + 3); chk(sqw_out == 1'b1, "R5 rate 1 toggle", sqw_out, 1);
    wait_until(w + 20);
    sqw_en = 1'b0;
    wait_until(w + 21); chk(sqw_out == 1'b0, "R5 disabled square wave", sqw_out, 0);
    wait_until(w + 22); chk(sqw_out == 1'b0, "R5 disabled square wave", sqw_out, 0);
    write_at(w + 40, 8'h60);
    sqw_en = 1'b1;

    // Freeze and resume.
    w = cyc + 5;
    write_at(w, 8'h23);
    cnt = 16384;
    expect_run(w, w + 1000, 3, 1'b0, cnt);
    write_at(w + 1000, 8'h03);
    wait_until(w + 1000);
    chk(reg_rdata[6:0] == 7'h03, "R7 readback freeze code", reg_rdata[6:0], 7'h03);
    wait_until(w + 1100);
    chk(!pe_pulse && !sec_tick, "R8 frozen divider quiet", pe_pulse, 0);
    r = w + 1200;
    write_at(r, 8'h23);
    expect_run(r, r + 15400, 3, 1'b0, cnt);
    wait_until(r + 15384);
    chk(sec_tick == 1'b1, "R8 count resumes after freeze", sec_tick, 1);
    write_at(r + 15400, 8'h60);

    // Gated reference: one tick every third cycle, rate 2.
    gate = 1'b1;
    w = cyc + 5;
    write_at(w, 8'h22);
    cnt = 16384;
    expect_run(w, w + 60, 2, 1'b1, cnt);
    first = pe_q[0];
    wait_until(first);
    chk(pe_pulse == 1'b1, "R9 event on second gated tick", pe_pulse, 1);
    wait_until(first + 1);
    chk(pe_pulse == 1'b0, "R9 no event between ticks", pe_pulse, 0);
    write_at(w + 60, 8'h60);
    gate = 1'b0;

    // Running with rate 0: no events, square wave stays low.
    w = cyc + 5;
    write_at(w, 8'h20);
    cnt = 16384;
    expect_run(w, w + 100, 0, 1'b0, cnt);
    wait_until(w + 50);
    chk(!pe_pulse, "R4 rate 0 gives no event", pe_pulse, 0);
    chk(!sqw_out, "R5 rate 0 square wave low", sqw_out, 0);
    write_at(w + 100, 8'h60);

    wait_until(cyc + 10);
    chk(pe_q.size() == 0, "R4 all periodic events seen", pe_q.size(), 0);
    chk(sec_q.size() == 0, "R3 all second ticks seen", sec_q.size(), 0);
    finish_run();
  end

endmodule